// File: doc/BRIEF.md
# Notebook Power State Sequencer

This block steps a portable system between three power states, ON, DOZE and SLEEP, based on how long the machine has been idle. Idle time is counted in ticks of a slow timebase strobe (`tick`, nominally one pulse per second). Activity resets the idle count. Activity means enabled strobes from six peripheral decodes, or I/O accesses that fall into one of two programmable address windows or one fixed window. Once the idle count reaches a programmed limit, the state drops from ON to DOZE. A second limit takes it from DOZE to SLEEP. A push button or an alarm input brings the machine back to ON. Activity also brings it back to ON, but only from DOZE.

Three power-control pins follow the state. Their level in each state comes from a configuration register. A backlight enable has its own idle timer. Two battery comparator inputs each produce a status flag and a one-clock interrupt. While the AC adapter is present, idle stepping is suspended. All configuration goes through a synchronous write port. The current state and a one-clock transition interrupt are outputs.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After synchronous reset, `state_out` is 0 (ON), `pwr_pin` is 3'b111, `bl_en` is 1, and both interrupt outputs are 0. The state encoding is ON=0, DOZE=1, SLEEP=2, and the value 3 never appears.
- R2: In ON with no enabled activity, the cycle after the Nth `tick` moves to DOZE, where N is register 0 (doze limit, bits 7:0). Activity, a state change or AC presence clears the idle count. A limit of 0 keeps the machine in ON.
- R3: In DOZE, the cycle after the Nth `tick` moves to SLEEP, where N is register 1 (sleep limit). A limit of 0 keeps the machine in DOZE. SLEEP is entered only from DOZE.
- R4: Enabled activity in DOZE returns the machine to ON on the next cycle. Activity in SLEEP leaves the state unchanged.
- R5: `wake_btn` or `wake_rtc` in DOZE or SLEEP returns the machine to ON on the next cycle.
- R6: While `ac_present` is 1, the next state is ON, the idle and backlight counts are cleared, and `bl_en` is 1.
- R7: `pwr_pin` updates together with `state_out`. It takes bits 2:0 of register 3 in ON, register 4 in DOZE and register 5 in SLEEP. Register 3 resets to 7, registers 4 and 5 reset to 0.
- R8: `bl_en` drops to 0 the cycle after the Nth idle `tick`, where N is register 2 and is nonzero. Activity or a wake input sets `bl_en` to 1 and clears the count. A limit of 0 keeps `bl_en` at 1.
- R9: Register 10 holds activity enables, reset 0x1FF. Bits 5:0 gate `dev_act[5:0]`, which are video, hard disk, floppy, serial, keyboard and parallel in that order. A strobe whose enable bit is 0 has no effect.
- R10: An `io_strobe` is activity when one of these holds. It falls in group A, where the address matches register 6 on all bits that are 0 in mask register 7, and enable bit 6 is set. It falls in group B (registers 8 and 9, enable bit 7). It falls in the fixed window 0x0060 to 0x006F, with enable bit 8. Addresses outside the windows are ignored.
- R11: `state_irq` is 1 for exactly the one cycle in which `state_out` shows a new value.
- R12: `batt_flag[i]` is `batt_low[i]` registered. `batt_irq[i]` is 1 for one cycle when the flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one cycle wide |
| dev_act | input | 6 | Peripheral activity strobes |
| io_strobe | input | 1 | I/O access valid |
| io_addr | input | 16 | I/O access address |
| wake_btn | input | 1 | Push-button wake |
| wake_rtc | input | 1 | Alarm wake |
| ac_present | input | 1 | AC adapter present |
| batt_low | input | 2 | Battery comparator outputs, two levels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write data |
| pwr_pin | output | 3 | Power-control pins |
| bl_en | output | 1 | Backlight enable |
| state_out | output | 2 | Current state |
| state_irq | output | 1 | State-change pulse |
| batt_flag | output | 2 | Battery warning flags |
| batt_irq | output | 2 | Battery warning pulses |

## Verification
Each timer is walked down with runs of ticks and no activity. Then activity is injected in each of the three states, which separates the DOZE rule (return to ON) from the SLEEP rule (ignore) and from the ON rule (count restart). Address-window accesses are placed just inside and just outside a masked group, and in the fixed window. These cases tell the mask logic apart from a full compare. A video strobe held high while its enable is cleared shows whether gating is applied. AC presence from DOZE, a zero doze limit, and battery edges cover the override and flag paths.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {PS_ON = 2'd0, PS_DOZE = 2'd1, PS_SLEEP = 2'd2} pstate_e;

  localparam int NUM_PINS = 3;
  localparam int NUM_GRP  = 2;
  localparam logic [NUM_PINS-1:0] RST_LVL_ON = '1;

  localparam logic [3:0] RA_DOZE  = 4'd0;
  localparam logic [3:0] RA_SLEEP = 4'd1;
  localparam logic [3:0] RA_BL    = 4'd2;
  localparam logic [3:0] RA_LVL0  = 4'd3;
  localparam logic [3:0] RA_GRP0  = 4'd6;
  localparam logic [3:0] RA_EN    = 4'd10;
endpackage

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs
  import pwr_seq_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int AW    = 16,
  parameter int EN_W  = 9
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [3:0]                        addr,
  input  logic [AW-1:0]                     wdata,
  output logic [TMR_W-1:0]                  doze_lim,
  output logic [TMR_W-1:0]                  sleep_lim,
  output logic [TMR_W-1:0]                  bl_lim,
  output logic [2:0][NUM_PINS-1:0]          lvl,
  output logic [NUM_GRP-1:0][AW-1:0]        grp_base,
  output logic [NUM_GRP-1:0][AW-1:0]        grp_mask,
  output logic [EN_W-1:0]                   act_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      doze_lim  <= '0;
      sleep_lim <= '0;
      bl_lim    <= '0;
      lvl[0]    <= RST_LVL_ON;
      lvl[1]    <= '0;
      lvl[2]    <= '0;
      act_en    <= '1;
    end else if (we) begin
      case (addr)
        RA_DOZE:      doze_lim  <= wdata[TMR_W-1:0];
        RA_SLEEP:     sleep_lim <= wdata[TMR_W-1:0];
        RA_BL:        bl_lim    <= wdata[TMR_W-1:0];
        RA_LVL0:      lvl[0]    <= wdata[NUM_PINS-1:0];
        RA_LVL0 + 1:  lvl[1]    <= wdata[NUM_PINS-1:0];
        RA_LVL0 + 2:  lvl[2]    <= wdata[NUM_PINS-1:0];
        RA_EN:        act_en    <= wdata[EN_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam logic [3:0] BASE_A = 4'(RA_GRP0 + 2 * g);
    localparam logic [3:0] MASK_A = 4'(RA_GRP0 + 2 * g + 1);
    always_ff @(posedge clk) begin
      if (rst) begin
        grp_base[g] <= '0;
        grp_mask[g] <= '0;
      end else if (we) begin
        if (addr == BASE_A) grp_base[g] <= wdata;
        if (addr == MASK_A) grp_mask[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/pwr_act_detect.sv
module pwr_act_detect
  import pwr_seq_pkg::*;
#(
  parameter int              NDEV     = 6,
  parameter int              AW       = 16,
  parameter int              EN_W     = NDEV + NUM_GRP + 1,
  parameter logic [AW-1:0]   FIX_BASE = 16'h0060,
  parameter logic [AW-1:0]   FIX_MASK = 16'h000F
) (
  input  logic [NDEV-1:0]             dev_act,
  input  logic                        io_strobe,
  input  logic [AW-1:0]               io_addr,
  input  logic [NUM_GRP-1:0][AW-1:0]  grp_base,
  input  logic [NUM_GRP-1:0][AW-1:0]  grp_mask,
  input  logic [EN_W-1:0]             act_en,
  output logic                        act
);
  logic [NUM_GRP-1:0] grp_hit;
  logic               fix_hit;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_match
    assign grp_hit[g] = io_strobe && (((io_addr ^ grp_base[g]) & ~grp_mask[g]) == '0);
  end

  assign fix_hit = io_strobe && (((io_addr ^ FIX_BASE) & ~FIX_MASK) == '0);

  assign act = (|(dev_act & act_en[NDEV-1:0]))
             | (|(grp_hit & act_en[NDEV +: NUM_GRP]))
             | (fix_hit & act_en[NDEV+NUM_GRP]);
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_seq_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic                      act,
  input  logic                      wake,
  input  logic                      ac,
  input  logic [TMR_W-1:0]          doze_lim,
  input  logic [TMR_W-1:0]          sleep_lim,
  input  logic [2:0][NUM_PINS-1:0]  lvl,
  output pstate_e                   state,
  output logic [NUM_PINS-1:0]       pwr_pin,
  output logic                      state_irq
);
  pstate_e             nxt;
  logic [TMR_W-1:0]    cnt;
  logic [TMR_W-1:0]    lim;
  logic [TMR_W:0]      cnt_inc;
  logic                counting;
  logic                timeout;
  logic [NUM_PINS-1:0] pin_nxt;

  assign lim      = (state == PS_ON) ? doze_lim : sleep_lim;
  assign cnt_inc  = {1'b0, cnt} + 1'b1;
  assign counting = tick && (lim != '0) && (state != PS_SLEEP);
  assign timeout  = counting && (cnt_inc >= {1'b0, lim});

  always_comb begin
    nxt = state;
    if (ac) begin
      nxt = PS_ON;
    end else begin
      unique case (state)
        PS_ON:    if (!act && timeout) nxt = PS_DOZE;
        PS_DOZE:  if (act || wake) nxt = PS_ON;
                  else if (timeout) nxt = PS_SLEEP;
        PS_SLEEP: if (wake) nxt = PS_ON;
        default:  nxt = PS_ON;
      endcase
    end
  end

  always_comb begin
    unique case (nxt)
      PS_DOZE:  pin_nxt = lvl[1];
      PS_SLEEP: pin_nxt = lvl[2];
      default:  pin_nxt = lvl[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PS_ON;
      cnt       <= '0;
      pwr_pin   <= RST_LVL_ON;
      state_irq <= 1'b0;
    end else begin
      state     <= nxt;
      state_irq <= (nxt != state);
      pwr_pin   <= pin_nxt;
      if (ac || act || (nxt != state)) cnt <= '0;
      else if (counting)               cnt <= cnt_inc[TMR_W-1:0];
    end
  end
endmodule

// File: rtl/pwr_bl_timer.sv
module pwr_bl_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             act,
  input  logic             wake,
  input  logic             ac,
  input  logic [TMR_W-1:0] bl_lim,
  output logic             bl_en
);
  logic [TMR_W-1:0] cnt;
  logic [TMR_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      bl_en <= 1'b1;
    end else if (ac || act || wake || (bl_lim == '0)) begin
      cnt   <= '0;
      bl_en <= 1'b1;
    end else if (tick && bl_en) begin
      cnt <= cnt_inc[TMR_W-1:0];
      if (cnt_inc >= {1'b0, bl_lim}) bl_en <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int NDEV   = 6,
  parameter int AW     = 16,
  parameter int NBATT  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [NDEV-1:0]     dev_act,
  input  logic                io_strobe,
  input  logic [AW-1:0]       io_addr,
  input  logic                wake_btn,
  input  logic                wake_rtc,
  input  logic                ac_present,
  input  logic [NBATT-1:0]    batt_low,
  input  logic                cfg_we,
  input  logic [3:0]          cfg_addr,
  input  logic [AW-1:0]       cfg_wdata,
  output logic [NUM_PINS-1:0] pwr_pin,
  output logic                bl_en,
  output logic [1:0]          state_out,
  output logic                state_irq,
  output logic [NBATT-1:0]    batt_flag,
  output logic [NBATT-1:0]    batt_irq
);
  localparam int EN_W = NDEV + NUM_GRP + 1;

  logic [TMR_W-1:0]           doze_lim, sleep_lim, bl_lim;
  logic [2:0][NUM_PINS-1:0]   lvl;
  logic [NUM_GRP-1:0][AW-1:0] grp_base, grp_mask;
  logic [EN_W-1:0]            act_en;
  logic                       act, wake;
  pstate_e                    state;

  assign wake      = wake_btn | wake_rtc;
  assign state_out = state;

  pwr_cfg_regs #(.TMR_W(TMR_W), .AW(AW), .EN_W(EN_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .doze_lim(doze_lim), .sleep_lim(sleep_lim), .bl_lim(bl_lim), .lvl(lvl),
    .grp_base(grp_base), .grp_mask(grp_mask), .act_en(act_en)
  );

  pwr_act_detect #(.NDEV(NDEV), .AW(AW), .EN_W(EN_W)) u_act (
    .dev_act(dev_act), .io_strobe(io_strobe), .io_addr(io_addr),
    .grp_base(grp_base), .grp_mask(grp_mask), .act_en(act_en), .act(act)
  );

  pwr_state_fsm #(.TMR_W(TMR_W)) u_fsm (
    .clk(clk), .rst(rst), .tick(tick), .act(act), .wake(wake), .ac(ac_present),
    .doze_lim(doze_lim), .sleep_lim(sleep_lim), .lvl(lvl),
    .state(state), .pwr_pin(pwr_pin), .state_irq(state_irq)
  );

  pwr_bl_timer #(.TMR_W(TMR_W)) u_bl (
    .clk(clk), .rst(rst), .tick(tick), .act(act), .wake(wake), .ac(ac_present),
    .bl_lim(bl_lim), .bl_en(bl_en)
  );

  for (genvar b = 0; b < NBATT; b++) begin : g_batt
    always_ff @(posedge clk) begin
      if (rst) begin
        batt_flag[b] <= 1'b0;
        batt_irq[b]  <= 1'b0;
      end else begin
        batt_flag[b] <= batt_low[b];
        batt_irq[b]  <= batt_low[b] & ~batt_flag[b];
      end
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] state_out,
  input logic       state_irq,
  input logic       wake_btn,
  input logic       wake_rtc,
  input logic       ac_present,
  input logic       bl_en,
  input logic [1:0] batt_flag,
  input logic [1:0] batt_irq
);
  p_state_legal_r1: assert property (@(posedge clk) disable iff (rst)
    state_out != 2'd3);

  p_sleep_from_doze_r3: assert property (@(posedge clk) disable iff (rst)
    (state_out == 2'd2 && $past(state_out) != 2'd2) |-> $past(state_out) == 2'd1);

  p_sleep_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state_out == 2'd2 && !wake_btn && !wake_rtc && !ac_present) |=> state_out == 2'd2);

  p_wake_to_on_r5: assert property (@(posedge clk) disable iff (rst)
    (state_out != 2'd0 && (wake_btn || wake_rtc)) |=> state_out == 2'd0);

  p_ac_override_r6: assert property (@(posedge clk) disable iff (rst)
    ac_present |=> (state_out == 2'd0 && bl_en));

  p_irq_on_change_r11: assert property (@(posedge clk) disable iff (rst)
    state_irq == (state_out != $past(state_out)));

  p_batt_irq_flag_r12: assert property (@(posedge clk) disable iff (rst)
    batt_irq[0] |-> batt_flag[0]);

  p_batt_irq_single_r12: assert property (@(posedge clk) disable iff (rst)
    batt_irq[1] |=> !batt_irq[1]);
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk i_chk (
  .clk(clk), .rst(rst), .state_out(state_out), .state_irq(state_irq),
  .wake_btn(wake_btn), .wake_rtc(wake_rtc), .ac_present(ac_present),
  .bl_en(bl_en), .batt_flag(batt_flag), .batt_irq(batt_irq)
);

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [5:0]  dev_act = '0;
  logic        io_strobe = 1'b0;
  logic [15:0] io_addr = '0;
  logic        wake_btn = 1'b0, wake_rtc = 1'b0, ac_present = 1'b0;
  logic [1:0]  batt_low = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [2:0]  pwr_pin;
  logic        bl_en, state_irq;
  logic [1:0]  state_out, batt_flag, batt_irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pwr_seq_ctrl i_pwr_seq_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .dev_act(dev_act), .io_strobe(io_strobe),
    .io_addr(io_addr), .wake_btn(wake_btn), .wake_rtc(wake_rtc),
    .ac_present(ac_present), .batt_low(batt_low), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pwr_pin(pwr_pin), .bl_en(bl_en),
    .state_out(state_out), .state_irq(state_irq), .batt_flag(batt_flag),
    .batt_irq(batt_irq)
  );

  // Behavioural reference model, advanced on every rising edge
  logic [15:0] m_reg [16];
  int m_state, m_cnt, m_blcnt;
  bit m_bl, m_irq;
  bit [2:0] m_pin;
  bit [1:0] m_flag, m_birq;

  function automatic bit m_activity();
    bit a = 0;
    for (int i = 0; i < 6; i++) if (dev_act[i] && m_reg[10][i]) a = 1;
    if (io_strobe) begin
      if (m_reg[10][6] && (((io_addr ^ m_reg[6]) & ~m_reg[7]) == 16'h0)) a = 1;
      if (m_reg[10][7] && (((io_addr ^ m_reg[8]) & ~m_reg[9]) == 16'h0)) a = 1;
      if (m_reg[10][8] && io_addr >= 16'h0060 && io_addr <= 16'h006F) a = 1;
    end
    return a;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) m_reg[i] = 16'h0;
      m_reg[3] = 16'h7;
      m_reg[10] = 16'h01FF;
      m_state = 0; m_cnt = 0; m_blcnt = 0; m_bl = 1; m_irq = 0;
      m_pin = 3'b111; m_flag = 0; m_birq = 0;
    end else begin
      bit act, wk, to;
      int lim, blim, ns;
      act = m_activity();
      wk = wake_btn || wake_rtc;
      lim = (m_state == 0) ? int'(m_reg[0][7:0]) : int'(m_reg[1][7:0]);
      blim = int'(m_reg[2][7:0]);
      to = tick && lim != 0 && m_state != 2 && (m_cnt + 1 >= lim);
      ns = m_state;
      if (ac_present) ns = 0;
      else if (m_state == 0) begin if (!act && to) ns = 1; end
      else if (m_state == 1) begin if (act || wk) ns = 0; else if (to) ns = 2; end
      else begin if (wk) ns = 0; end
      if (ac_present || act || ns != m_state) m_cnt = 0;
      else if (tick && lim != 0 && m_state != 2) m_cnt++;
      if (ac_present || act || wk || blim == 0) begin m_blcnt = 0; m_bl = 1; end
      else if (tick && m_bl) begin m_blcnt++; if (m_blcnt >= blim) m_bl = 0; end
      m_irq = (ns != m_state);
      m_pin = m_reg[3 + ns][2:0];
      m_state = ns;
      m_birq = batt_low & ~m_flag;
      m_flag = batt_low;
      if (cfg_we) m_reg[cfg_addr] = cfg_wdata;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle compare against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 state vs model", int'(state_out), m_state);
      chk("R7 pins vs model", int'(pwr_pin), int'(m_pin));
      chk("R8 backlight vs model", int'(bl_en), int'(m_bl));
      chk("R11 state_irq vs model", int'(state_irq), int'(m_irq));
      chk("R12 flags vs model", int'(batt_flag), int'(m_flag));
      chk("R12 irqs vs model", int'(batt_irq), int'(m_birq));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic io_hit(input logic [15:0] a);
    io_strobe = 1'b1; io_addr = a;
    @(negedge clk);
    io_strobe = 1'b0;
  endtask

  task automatic dev_pulse(input int i);
    dev_act[i] = 1'b1;
    @(negedge clk);
    dev_act = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", int'(state_out), 0);
    chk("R1 reset pins", int'(pwr_pin), 7);
    chk("R1 reset backlight", int'(bl_en), 1);
    chk("R1 reset irq", int'(state_irq), 0);

    wr(4'd0, 16'd3); wr(4'd1, 16'd2); wr(4'd2, 16'd5);
    wr(4'd3, 16'd5); wr(4'd4, 16'd3); wr(4'd5, 16'd0);
    @(negedge clk);
    chk("R7 ON level programmed", int'(pwr_pin), 5);

    ticks(3);
    chk("R2 doze after limit", int'(state_out), 1);
    chk("R7 DOZE level", int'(pwr_pin), 3);

    dev_pulse(4);
    chk("R4 activity wakes from DOZE", int'(state_out), 0);
    chk("R11 irq on return", int'(state_irq), 1);

    ticks(3);
    ticks(2);
    chk("R3 sleep after limit", int'(state_out), 2);
    chk("R7 SLEEP level", int'(pwr_pin), 0);
    chk("R8 backlight off", int'(bl_en), 0);

    dev_pulse(1);
    chk("R4 activity ignored in SLEEP", int'(state_out), 2);
    chk("R8 activity restores backlight", int'(bl_en), 1);

    wake_rtc = 1'b1; @(negedge clk); wake_rtc = 1'b0;
    chk("R5 alarm wakes from SLEEP", int'(state_out), 0);

    wr(4'd10, 16'h01FE);
    dev_act[0] = 1'b1;
    ticks(3);
    dev_act = '0;
    chk("R9 disabled video ignored", int'(state_out), 1);

    wake_btn = 1'b1; @(negedge clk); wake_btn = 1'b0;
    chk("R5 button wakes from DOZE", int'(state_out), 0);

    wr(4'd6, 16'h0300); wr(4'd7, 16'h000F);
    wr(4'd8, 16'h02F8); wr(4'd9, 16'h0007);
    ticks(3);
    io_hit(16'h030C);
    chk("R10 group A hit", int'(state_out), 0);
    ticks(3);
    io_hit(16'h02F0);
    chk("R10 outside group B ignored", int'(state_out), 1);
    io_hit(16'h02FF);
    chk("R10 group B hit", int'(state_out), 0);
    ticks(3);
    io_hit(16'h0064);
    chk("R10 fixed window hit", int'(state_out), 0);

    ticks(3);
    ac_present = 1'b1;
    @(negedge clk);
    chk("R6 AC forces ON", int'(state_out), 0);
    ticks(6);
    chk("R6 timers held under AC", int'(state_out), 0);
    chk("R6 backlight on under AC", int'(bl_en), 1);
    ac_present = 1'b0;

    wr(4'd0, 16'd0);
    ticks(5);
    chk("R2 zero limit disables", int'(state_out), 0);

    batt_low[0] = 1'b1;
    @(negedge clk);
    chk("R12 flag0 set", int'(batt_flag[0]), 1);
    chk("R12 irq0 pulse", int'(batt_irq[0]), 1);
    @(negedge clk);
    chk("R12 irq0 one cycle", int'(batt_irq[0]), 0);
    batt_low[1] = 1'b1;
    @(negedge clk);
    chk("R12 irq1 pulse", int'(batt_irq[1]), 1);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule